// File: doc/BRIEF.md
# Packed saturating rounding doubling multiply-accumulate unit

This unit treats a 64-bit or 128-bit register as a row of packed signed lanes, either 16 or 32 bits wide. For every lane it doubles the product of two operands, keeps the rounded high half and adds it to an accumulator lane, or subtracts it. Doubling, rounding and accumulation are one wide expression: the accumulator is scaled up by one less than the element width, the product is added or subtracted, half of the final unit is added, and the sum is shifted right arithmetically. Saturation is applied once, to that final value.

A lane result that does not fit the element width is clamped to the nearest limit. Any active lane that clamps sets a sticky saturation flag that only reset or the clear input removes. When only the lower 64 bits are active, the upper half of the result is written as zero, and its lanes cannot set the flag. Lane arithmetic is combinational. The result register and the flag update on a valid strobe.

Top module: `satmac_vec`

## Requirements
- R1: With `esize_i`=0, each 16-bit lane gives floor((acc·2^15 ± a·b + 2^14) / 2^15), computed without loss of precision.
- R2: With `esize_i`=1, each 32-bit lane gives floor((acc·2^31 ± a·b + 2^30) / 2^31), computed without loss of precision.
- R3: A lane value above the largest signed element gives the largest signed element (0x7FFF or 0x7FFFFFFF). A value below the smallest gives the smallest (0x8000 or 0x80000000).
- R4: With `sub_i`=1 the product term is subtracted instead of added. The rounding constant and the shift stay the same.
- R5: 16-bit lane k reads bits [16k+15:16k] of every operand and writes the same bits of the result. 32-bit lane k uses bits [32k+31:32k]. Lanes are computed independently.
- R6: With `full_i`=0, result bits [127:64] are written as zero, and lanes in that half never set the flag. With `full_i`=1 all 128 bits are active.
- R7: A valid operation in which any active lane saturates sets `sat_o` to 1 at the next edge. `sat_o` then stays 1 until reset or clear.
- R8: `sat_clr_i`=1 drives `sat_o` to 0 at the next edge, with or without `valid_i`, even when a saturating operation is applied in the same cycle.
- R9: `result_o` takes the new value only at an edge where `valid_i`=1 and holds otherwise. Without a clear, `sat_o` changes only through a valid operation.
- R10: After reset, `result_o` is zero and `sat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Register the computed vector and update the flag |
| sub_i | input | 1 | 0 adds the product term, 1 subtracts it |
| esize_i | input | 1 | Element size: 0 = 16-bit lanes, 1 = 32-bit lanes |
| full_i | input | 1 | 0 = lower 64 bits active, 1 = all 128 bits active |
| mcand_i | input | 128 | Packed multiplicand lanes |
| mplier_i | input | 128 | Packed multiplier lanes |
| acc_i | input | 128 | Packed accumulator lanes |
| sat_clr_i | input | 1 | Synchronous clear of the saturation flag |
| result_o | output | 128 | Registered packed result |
| sat_o | output | 1 | Sticky cumulative saturation flag |

## Verification
Two functions can meet in one cycle: the clear request and the flag set caused by a saturating lane. The bench applies a clear together with operands that make the lower lanes clamp. It expects the saturated vector on `result_o` and `sat_o` at 0 one edge later. Random traffic also raises the clear on about one operation in eight, some of them saturating. A bench model that gives the clear priority decides each expected flag value.

// File: rtl/satmac_pkg.sv
package satmac_pkg;

  typedef enum logic {
    ESZ_HALF = 1'b0,
    ESZ_WORD = 1'b1
  } esz_t;

  typedef struct packed {
    logic        sat;
    logic [15:0] val;
  } res16_t;

  typedef struct packed {
    logic        sat;
    logic [31:0] val;
  } res32_t;

  // 16-bit element: fused doubling, rounding and accumulation in 34 bits
  function automatic res16_t fuse16(input logic signed [15:0] a,
                                    input logic signed [15:0] b,
                                    input logic signed [15:0] acc,
                                    input logic               sub);
    logic signed [33:0] ax, bx, cx, prod, sum, q;
    res16_t r;
    ax   = 34'(a);
    bx   = 34'(b);
    cx   = 34'(acc);
    prod = ax * bx;
    sum  = (cx <<< 15) + (sub ? -prod : prod) + 34'sd16384;
    q    = sum >>> 15;
    if (q > 34'sd32767) begin
      r.sat = 1'b1;
      r.val = 16'h7FFF;
    end else if (q < -34'sd32768) begin
      r.sat = 1'b1;
      r.val = 16'h8000;
    end else begin
      r.sat = 1'b0;
      r.val = q[15:0];
    end
    return r;
  endfunction

  // 32-bit element: same construction in 66 bits
  function automatic res32_t fuse32(input logic signed [31:0] a,
                                    input logic signed [31:0] b,
                                    input logic signed [31:0] acc,
                                    input logic               sub);
    logic signed [65:0] ax, bx, cx, prod, sum, q;
    logic signed [65:0] hi_lim, lo_lim, rnd;
    res32_t r;
    ax     = 66'(a);
    bx     = 66'(b);
    cx     = 66'(acc);
    rnd    = 66'sd1 <<< 30;
    hi_lim = (66'sd1 <<< 31) - 66'sd1;
    lo_lim = -(66'sd1 <<< 31);
    prod   = ax * bx;
    sum    = (cx <<< 31) + (sub ? -prod : prod) + rnd;
    q      = sum >>> 31;
    if (q > hi_lim) begin
      r.sat = 1'b1;
      r.val = 32'h7FFF_FFFF;
    end else if (q < lo_lim) begin
      r.sat = 1'b1;
      r.val = 32'h8000_0000;
    end else begin
      r.sat = 1'b0;
      r.val = q[31:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/satmac_lane16.sv
module satmac_lane16
  import satmac_pkg::*;
(
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic [15:0] acc_i,
  input  logic        sub_i,
  output logic [15:0] res_o,
  output logic        sat_o
);
  res16_t r;
  always_comb begin
    r     = fuse16(a_i, b_i, acc_i, sub_i);
    res_o = r.val;
    sat_o = r.sat;
  end
endmodule

// File: rtl/satmac_lane32.sv
module satmac_lane32
  import satmac_pkg::*;
(
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic [31:0] acc_i,
  input  logic        sub_i,
  output logic [31:0] res_o,
  output logic        sat_o
);
  res32_t r;
  always_comb begin
    r     = fuse32(a_i, b_i, acc_i, sub_i);
    res_o = r.val;
    sat_o = r.sat;
  end
endmodule

// File: rtl/satmac_sticky.sv
module satmac_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/satmac_vec.sv
module satmac_vec
  import satmac_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             sub_i,
  input  logic             esize_i,
  input  logic             full_i,
  input  logic [VEC_W-1:0] mcand_i,
  input  logic [VEC_W-1:0] mplier_i,
  input  logic [VEC_W-1:0] acc_i,
  input  logic             sat_clr_i,
  output logic [VEC_W-1:0] result_o,
  output logic             sat_o
);
  localparam int NSLOT      = VEC_W / 32;
  localparam int HALF_SLOTS = NSLOT / 2;

  logic [VEC_W-1:0] next_res;
  logic [NSLOT-1:0] slot_event;
  logic             word_mode;
  logic             sat_event;   // some active lane clamps this cycle
  logic             flag_set;

  assign word_mode = (esz_t'(esize_i) == ESZ_WORD);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [15:0] lo_res, hi_res;
    logic [31:0] w_res;
    logic        lo_sat, hi_sat, w_sat;
    logic [31:0] slot_res;
    logic        slot_sat, active;

    satmac_lane16 u_lo (
      .a_i  (mcand_i [g*32 +: 16]),
      .b_i  (mplier_i[g*32 +: 16]),
      .acc_i(acc_i   [g*32 +: 16]),
      .sub_i(sub_i),
      .res_o(lo_res),
      .sat_o(lo_sat)
    );
    satmac_lane16 u_hi (
      .a_i  (mcand_i [g*32+16 +: 16]),
      .b_i  (mplier_i[g*32+16 +: 16]),
      .acc_i(acc_i   [g*32+16 +: 16]),
      .sub_i(sub_i),
      .res_o(hi_res),
      .sat_o(hi_sat)
    );
    satmac_lane32 u_w (
      .a_i  (mcand_i [g*32 +: 32]),
      .b_i  (mplier_i[g*32 +: 32]),
      .acc_i(acc_i   [g*32 +: 32]),
      .sub_i(sub_i),
      .res_o(w_res),
      .sat_o(w_sat)
    );

    always_comb begin
      active   = (g < HALF_SLOTS) || full_i;
      slot_res = word_mode ? w_res : {hi_res, lo_res};
      slot_sat = word_mode ? w_sat : (lo_sat | hi_sat);
      next_res[g*32 +: 32] = active ? slot_res : 32'h0;
      slot_event[g]        = active & slot_sat;
    end
  end

  assign sat_event = |slot_event;
  assign flag_set  = valid_i & sat_event;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result_o <= '0;
    else if (valid_i) result_o <= next_res;
  end

  satmac_sticky u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (sat_clr_i),
    .set_i (flag_set),
    .flag_o(sat_o)
  );
endmodule

// File: rtl/satmac_chk.sv
module satmac_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic             full_i,
  input logic             sat_clr_i,
  input logic             sat_event,
  input logic [VEC_W-1:0] result_o,
  input logic             sat_o
);
  localparam int HALF = VEC_W / 2;

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !sat_clr_i) |=> sat_o);

  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sat_event && !sat_clr_i) |=> sat_o);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr_i |=> !sat_o);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_o && !(valid_i && sat_event)) |=> !sat_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !full_i) |=> (result_o[VEC_W-1:HALF] == '0));
endmodule

bind satmac_vec satmac_chk #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .full_i   (full_i),
  .sat_clr_i(sat_clr_i),
  .sat_event(sat_event),
  .result_o (result_o),
  .sat_o    (sat_o)
);

// File: tb/satmac_vec_bench.sv
`timescale 1ns/1ps
module satmac_vec_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0, sub_i = 1'b0, esize_i = 1'b0, full_i = 1'b0;
  logic         sat_clr_i = 1'b0;
  logic [127:0] mcand_i = '0, mplier_i = '0, acc_i = '0;
  logic [127:0] result_o;
  logic         sat_o;

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_res = '0;
  logic         exp_flag = 1'b0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  satmac_vec u_satmac_vec (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sub_i(sub_i),
    .esize_i(esize_i), .full_i(full_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .acc_i(acc_i), .sat_clr_i(sat_clr_i),
    .result_o(result_o), .sat_o(sat_o)
  );

  // Reference element: exact integer arithmetic in 72 bits, scaled by multiplication
  function automatic logic [31:0] ref_elem(input int w, input logic sub,
      input logic [31:0] ra, input logic [31:0] rb, input logic [31:0] rc,
      output logic sat);
    logic signed [71:0] a, b, c, t, q, scale, maxv, minv;
    if (w == 16) begin
      a = 72'($signed(ra[15:0])); b = 72'($signed(rb[15:0])); c = 72'($signed(rc[15:0]));
    end else begin
      a = 72'($signed(ra)); b = 72'($signed(rb)); c = 72'($signed(rc));
    end
    scale = 72'sd1 <<< (w - 1);
    t = c * scale;
    if (sub) t = t - a * b; else t = t + a * b;
    t = t + scale / 2;
    q = t >>> (w - 1);
    maxv = scale - 1;
    minv = -scale;
    sat = 1'b0;
    if (q > maxv)      begin sat = 1'b1; q = maxv; end
    else if (q < minv) begin sat = 1'b1; q = minv; end
    return q[31:0];
  endfunction

  function automatic logic [127:0] ref_vec(input logic sub, input logic esz,
      input logic full, input logic [127:0] a, input logic [127:0] b,
      input logic [127:0] c, output logic sat);
    logic [127:0] r;
    logic s;
    logic [31:0] e;
    r = '0; sat = 1'b0;
    if (!esz) begin
      for (int k = 0; k < 8; k++) begin
        if (k < 4 || full) begin
          e = ref_elem(16, sub, {16'h0, a[k*16 +: 16]}, {16'h0, b[k*16 +: 16]},
                       {16'h0, c[k*16 +: 16]}, s);
          r[k*16 +: 16] = e[15:0];
          sat = sat | s;
        end
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (k < 2 || full) begin
          e = ref_elem(32, sub, a[k*32 +: 32], b[k*32 +: 32], c[k*32 +: 32], s);
          r[k*32 +: 32] = e;
          sat = sat | s;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act_r,
                       input logic [127:0] exp_r, input logic act_f, input logic exp_f);
    checks++;
    if (act_r !== exp_r) begin
      errors++;
      $display("FAIL %s result actual=%h expected=%h", req, act_r, exp_r);
    end
    checks++;
    if (act_f !== exp_f) begin
      errors++;
      $display("FAIL %s flag actual=%b expected=%b", req, act_f, exp_f);
    end
  endtask

  // Called at a negative edge; returns at the next negative edge after checking
  task automatic do_op(input string req, input logic sub, input logic esz,
      input logic full, input logic [127:0] a, input logic [127:0] b,
      input logic [127:0] c, input logic clr);
    logic s;
    valid_i = 1'b1; sub_i = sub; esize_i = esz; full_i = full;
    mcand_i = a; mplier_i = b; acc_i = c; sat_clr_i = clr;
    exp_res = ref_vec(sub, esz, full, a, b, c, s);
    exp_flag = clr ? 1'b0 : (exp_flag | s);
    @(negedge clk);
    valid_i = 1'b0; sat_clr_i = 1'b0;
    check(req, result_o, exp_res, sat_o, exp_flag);
  endtask

  task automatic idle(input string req, input logic clr);
    valid_i = 1'b0; sat_clr_i = clr;
    mcand_i = {4{$urandom()}}; mplier_i = {4{$urandom()}}; acc_i = {4{$urandom()}};
    if (clr) exp_flag = 1'b0;
    @(negedge clk);
    sat_clr_i = 1'b0;
    check(req, result_o, exp_res, sat_o, exp_flag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] ra, rb, rc;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R10 reset", result_o, 128'h0, sat_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5: plain 16-bit lanes, differing per lane
    do_op("R1 R5 16-bit add", 1'b0, 1'b0, 1'b1,
          128'h4000_2000_FFFF_0001_1234_8001_7FFF_0100,
          128'h4000_0003_FFFF_7FFF_0F0F_0002_0001_0100,
          128'h0000_0010_FFF0_0005_0100_0001_0000_7000, 1'b0);
    // R3 R7: both-minimum operands saturate positive, flag sets
    do_op("R3 R7 16-bit positive clamp", 1'b0, 1'b0, 1'b1,
          {8{16'h8000}}, {8{16'h8000}}, '0, 1'b0);
    // R7: flag stays set through a benign operation
    do_op("R7 sticky", 1'b0, 1'b0, 1'b1, {8{16'h0100}}, {8{16'h0100}}, '0, 1'b0);
    // R9: no valid, inputs change, result holds
    idle("R9 hold", 1'b0);
    // R8: clear without valid
    idle("R8 clear alone", 1'b1);
    // R4 R3: subtract clamps negative
    do_op("R4 R3 16-bit negative clamp", 1'b1, 1'b0, 1'b1,
          {8{16'h7FFF}}, {8{16'h7FFF}}, {8{16'h8000}}, 1'b0);
    // R8: clear and saturation in the same cycle; clear wins
    do_op("R8 clear beats set", 1'b0, 1'b0, 1'b1,
          {8{16'h8000}}, {8{16'h8000}}, '0, 1'b1);
    // R6: narrow mode, only upper lanes would saturate
    do_op("R6 narrow 16-bit", 1'b0, 1'b0, 1'b0,
          {{4{16'h8000}}, {4{16'h0200}}}, {{4{16'h8000}}, {4{16'h0300}}},
          {{4{16'h7FFF}}, {4{16'h0001}}}, 1'b0);
    do_op("R6 narrow 32-bit", 1'b1, 1'b1, 1'b0,
          {{2{32'h7FFF_FFFF}}, {2{32'h0001_0000}}}, {{2{32'h7FFF_FFFF}}, {2{32'h0000_8000}}},
          {{2{32'h8000_0000}}, {2{32'h0000_0007}}}, 1'b0);
    // R2 R3: 32-bit positive clamp
    do_op("R2 R3 32-bit clamp", 1'b0, 1'b1, 1'b1,
          {4{32'h8000_0000}}, {4{32'h8000_0000}}, '0, 1'b1);
    do_op("R2 R3 32-bit clamp set", 1'b0, 1'b1, 1'b1,
          {4{32'h8000_0000}}, {4{32'h8000_0000}}, '0, 1'b0);
    // R5: one low lane clamps while its upper neighbour does not
    do_op("R5 lane independence", 1'b0, 1'b0, 1'b1,
          {16'h1000, 16'h7FFF, {6{16'h0000}}}, {16'h1000, 16'h7FFF, {6{16'h0000}}},
          {16'h0003, 16'h7FFF, {6{16'h0001}}}, 1'b1);
    do_op("R5 lane independence low", 1'b0, 1'b0, 1'b1,
          {{7{16'h0040}}, 16'h7FFF}, {{7{16'h0040}}, 16'h7FFF},
          {{7{16'hFFFE}}, 16'h7FFF}, 1'b1);

    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 4; k++) begin
        ra[k*32 +: 32] = $urandom();
        rb[k*32 +: 32] = $urandom();
        rc[k*32 +: 32] = $urandom();
      end
      if (($urandom() & 3) == 0) begin
        ra = {8{16'h8000}} ^ (ra & {8{16'h0003}});
        rb = {8{16'h8000}} ^ (rb & {8{16'h0003}});
      end
      if (($urandom() & 7) == 0)
        idle("R9 random hold", ($urandom() & 1) == 1);
      do_op("R1 R2 R4 R6 R7 R8 random", 1'($urandom()), 1'($urandom()),
            1'($urandom()), ra, rb, rc, (($urandom() & 7) == 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule